// File: doc/BRIEF.md
# TPM SPI Register Transaction Controller

This block acts as the SPI controller for a single TPM-class target. Each accepted request performs one register access. A request carries a direction flag, a length code and a 24-bit register address. The block asserts chip select, sends a four-byte command header and then honours the target's wait-state handshake. It polls with single bytes until the target signals that it is ready, and only then moves the data bytes. Chip select stays low from the first header bit to the last data bit.

Write data comes from the user one byte at a time. The block pulses a pop strobe each time it takes a byte from the data input. Read data returns one byte per valid strobe. On completion the block pulses done, with an error flag that is set only when the target stalls longer than the wait limit.

An optional wake mode sends a short chip-select pulse, followed by a settle pause, before the header. This happens on the first access after reset and on any access that comes after a long idle gap. All time limits are given in microseconds and are converted to clock cycles through a clock-frequency parameter.

Top module: `tpmspi_xact_master`

## Requirements
- R1: Header byte 0 is sent first. Its bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 equal `req_len_m1`.
- R2: Header bytes 1, 2 and 3 carry `req_addr[23:16]`, `req_addr[15:8]` and `req_addr[7:0]` in that order.
- R3: The data phase moves exactly `req_len_m1 + 1` bytes, so lengths 1 through 64 are supported.
- R4: Chip select falls once per access (without a wake pulse) and stays low through the header, the wait polls and the data. It rises after the last data byte.
- R5: If bit 0 of the byte received during header byte 3 is 1, the data phase starts next. Otherwise the block sends poll bytes until one returns bit 0 set. No other received bit affects this decision.
- R6: If polling lasts longer than `WAIT_US` microseconds, the block ends the access at the next byte boundary. It releases chip select, moves no data bytes and raises `err` together with `done`.
- R7: With `wake_en` high, the first access after reset, and any access that starts more than `WAKE_GAP_US` after the previous one ended, begins with chip select held low for exactly `WAKE_PULSE_US` worth of cycles. Chip select then stays high for at least `WAKE_SETTLE_US` before the header.
- R8: No wake pulse is sent when `wake_en` is low, or when the previous access ended within the gap window.
- R9: SPI mode 0 is used, MSB first. `sck` is low whenever chip select is high. `mosi` is 0 for every bit of poll bytes and of read-data bytes.
- R10: `busy` is high from the cycle after a request is accepted until `done` pulses. Requests that arrive while busy are ignored.
- R11: Write bytes are taken from `wr_data` in order, one per `wr_pop` pulse. Read bytes appear on `rd_data` in order, one per `rd_valid` pulse.
- R12: After reset `cs_n` is 1, `sck` is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an access (taken when idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len_m1 | input | 6 | Data length minus one |
| req_addr | input | 24 | Target register address |
| wake_en | input | 1 | Enable the wake pulse mode |
| wr_data | input | 8 | Next write byte, taken when `wr_pop` is high |
| wr_pop | output | 1 | Write byte consumed this cycle |
| rd_valid | output | 1 | Read byte valid on `rd_data` |
| rd_data | output | 8 | Received data byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Wait-limit error, valid with `done` |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Controller-to-target data |
| miso | input | 1 | Target-to-controller data |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench uses a behavioural SPI target whose stall length can be programmed. Its wait responses use 0xFE, so a design that tested any bit other than bit 0 would leave the wait phase too early or too late. That would show up as a wrong poll count or a shifted read-data stream. A stall that never ends checks the abort path: a design that missed the limit would hang until the watchdog fires, and one that released chip select without flagging an error would report `err` low. Wake handling is checked at the start after reset, on a back-to-back access, after a long idle gap and with the mode disabled. A gap timer that restarted at the wrong moment, or a pulse that was too long or too short, would change the chip-select fall count or the measured low width. A request injected mid-access would produce a second frame or a corrupted header if it were not ignored.

// File: rtl/tpmspi_pkg.sv
package tpmspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE_CS,
        ST_WAKE_GAP,
        ST_HEADER,
        ST_POLL,
        ST_DATA,
        ST_FINISH
    } xact_state_e;

    localparam int HDR_LAST = 3;

    typedef struct packed {
        xact_state_e st;
        logic        rd;
        logic [5:0]  len_m1;
        logic [23:0] addr;
        logic [5:0]  idx;
        logic        err;
        logic        seen;
        logic        rdv;
        logic [7:0]  rdat;
    } xact_regs_t;

    // Command header byte selected by position; position 0 carries the opcode.
    function automatic logic [7:0] hdr_byte(input logic        rd,
                                            input logic [5:0]  len_m1,
                                            input logic [23:0] addr,
                                            input logic [1:0]  pos);
        logic [7:0] b;
        case (pos)
            2'd0:    b = {rd, 1'b1, len_m1};
            2'd1:    b = addr[23:16];
            2'd2:    b = addr[15:8];
            default: b = addr[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tpmspi_elapsed.sv
module tpmspi_elapsed #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (cnt_q != {W{1'b1}})
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/tpmspi_byte_shifter.sv
module tpmspi_byte_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DW-1:0] DIV_TOP = DW'(HALF_CYC - 1);

    typedef struct packed {
        logic          active;
        logic          sck;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.active = 1'b1;
            d.sck    = 1'b0;
            d.div    = '0;
            d.bitn   = '0;
            d.tx     = tx_byte;
        end else if (q.active) begin
            if (q.div == DIV_TOP) begin
                d.div = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.bitn == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.tx   = {q.tx[6:0], 1'b0};
                    end
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck       = q.sck;
    assign mosi      = q.tx[7];
    assign active    = q.active;
    assign byte_done = q.done;
    assign rx_byte   = q.rx;

    // A byte completes on a falling SCK edge (mode 0 framing).
    p_byte_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> ($past(q.sck) && !q.sck));

endmodule

// File: rtl/tpmspi_xact_master.sv
module tpmspi_xact_master
    import tpmspi_pkg::*;
#(
    parameter int CLK_MHZ        = 100,
    parameter int SCK_HALF       = 4,
    parameter int WAIT_US        = 100000,
    parameter int WAKE_GAP_US    = 900000,
    parameter int WAKE_PULSE_US  = 1,
    parameter int WAKE_SETTLE_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [5:0]  req_len_m1,
    input  logic [23:0] req_addr,
    input  logic        wake_en,
    input  logic [7:0]  wr_data,
    output logic        wr_pop,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    localparam int WAIT_CYC   = CLK_MHZ * WAIT_US;
    localparam int GAP_CYC    = CLK_MHZ * WAKE_GAP_US;
    localparam int PULSE_CYC  = CLK_MHZ * WAKE_PULSE_US;
    localparam int SETTLE_CYC = CLK_MHZ * WAKE_SETTLE_US;
    localparam int PH_MAX     = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int WAIT_W     = $clog2(WAIT_CYC + 1);
    localparam int GAP_W      = $clog2(GAP_CYC + 1);
    localparam int PH_W       = $clog2(PH_MAX + 1);

    xact_regs_t d, q;

    logic       sh_start, sh_active, sh_done;
    logic [7:0] sh_tx, sh_rx;
    logic       ph_clr, ph_exp, wait_exp, gap_exp;
    logic [PH_W-1:0] ph_limit;

    tpmspi_byte_shifter #(.HALF_CYC(SCK_HALF)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .active    (sh_active),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    tpmspi_elapsed #(.W(WAIT_W)) u_wait_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (q.st != ST_POLL),
        .limit   (WAIT_W'(WAIT_CYC)),
        .expired (wait_exp)
    );

    tpmspi_elapsed #(.W(GAP_W)) u_gap_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (q.st == ST_FINISH),
        .limit   (GAP_W'(GAP_CYC)),
        .expired (gap_exp)
    );

    assign ph_limit = (q.st == ST_WAKE_CS) ? PH_W'(PULSE_CYC - 1)
                                           : PH_W'(SETTLE_CYC - 1);

    tpmspi_elapsed #(.W(PH_W)) u_phase_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ph_clr),
        .limit   (ph_limit),
        .expired (ph_exp)
    );

    always_comb begin
        d        = q;
        d.rdv    = 1'b0;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        wr_pop   = 1'b0;
        ph_clr   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.rd     = req_read;
                    d.len_m1 = req_len_m1;
                    d.addr   = req_addr;
                    d.err    = 1'b0;
                    d.idx    = '0;
                    if (wake_en && (!q.seen || gap_exp)) begin
                        d.st   = ST_WAKE_CS;
                        ph_clr = 1'b1;
                    end else begin
                        d.st     = ST_HEADER;
                        sh_start = 1'b1;
                        sh_tx    = hdr_byte(req_read, req_len_m1, req_addr, 2'd0);
                    end
                end
            end
            ST_WAKE_CS: begin
                if (ph_exp) begin
                    d.st   = ST_WAKE_GAP;
                    ph_clr = 1'b1;
                end
            end
            ST_WAKE_GAP: begin
                if (ph_exp) begin
                    d.st     = ST_HEADER;
                    d.idx    = '0;
                    sh_start = 1'b1;
                    sh_tx    = hdr_byte(q.rd, q.len_m1, q.addr, 2'd0);
                end
            end
            ST_HEADER: begin
                if (sh_done) begin
                    if (q.idx != 6'(HDR_LAST)) begin
                        d.idx    = q.idx + 6'd1;
                        sh_start = 1'b1;
                        sh_tx    = hdr_byte(q.rd, q.len_m1, q.addr, q.idx[1:0] + 2'd1);
                    end else if (sh_rx[0]) begin
                        d.st     = ST_DATA;
                        d.idx    = '0;
                        sh_start = 1'b1;
                        sh_tx    = q.rd ? 8'h00 : wr_data;
                        wr_pop   = !q.rd;
                    end else begin
                        d.st     = ST_POLL;
                        sh_start = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (sh_done) begin
                    if (sh_rx[0]) begin
                        d.st     = ST_DATA;
                        d.idx    = '0;
                        sh_start = 1'b1;
                        sh_tx    = q.rd ? 8'h00 : wr_data;
                        wr_pop   = !q.rd;
                    end else if (wait_exp) begin
                        d.st  = ST_FINISH;
                        d.err = 1'b1;
                    end else begin
                        sh_start = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (sh_done) begin
                    if (q.rd) begin
                        d.rdv  = 1'b1;
                        d.rdat = sh_rx;
                    end
                    if (q.idx == q.len_m1) begin
                        d.st = ST_FINISH;
                    end else begin
                        d.idx    = q.idx + 6'd1;
                        sh_start = 1'b1;
                        sh_tx    = q.rd ? 8'h00 : wr_data;
                        wr_pop   = !q.rd;
                    end
                end
            end
            ST_FINISH: begin
                d.st   = ST_IDLE;
                d.seen = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = (q.st == ST_FINISH);
    assign err      = done && q.err;
    assign cs_n     = !((q.st == ST_WAKE_CS) || (q.st == ST_HEADER) ||
                        (q.st == ST_POLL)    || (q.st == ST_DATA));
    assign rd_valid = q.rdv;
    assign rd_data  = q.rdat;

    // R9: clock stays low while the target is deselected.
    p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R9: controller drives zeros on poll bytes and read-data bytes.
    p_mosi_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_POLL) || ((q.st == ST_DATA) && q.rd)) |-> !mosi);

    // R4: a new byte is only launched once the previous one has ended.
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_active);

    // R10: busy cannot drop before the completion pulse.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11: read bytes are only delivered inside an access.
    p_rdv_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R6: an error completion can only follow the wait phase.
    p_err_from_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(q.st == ST_POLL));

endmodule

// File: tb/tb_tpmspi_xact_master.sv
module tb_tpmspi_xact_master;

    localparam int CLK_MHZ    = 1;
    localparam int PULSE_US   = 3;
    localparam int SETTLE_US  = 20;
    localparam int GAP_US     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [5:0]  req_len_m1 = '0;
    logic [23:0] req_addr = '0;
    logic        wake_en = 1'b0;
    logic [7:0]  wr_data;
    logic        wr_pop, rd_valid, busy, done, err, sck, mosi, miso, cs_n;
    logic [7:0]  rd_data;

    always #5 clk = ~clk;

    tpmspi_xact_master #(
        .CLK_MHZ(CLK_MHZ), .SCK_HALF(2), .WAIT_US(200),
        .WAKE_GAP_US(GAP_US), .WAKE_PULSE_US(PULSE_US), .WAKE_SETTLE_US(SETTLE_US)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_len_m1(req_len_m1), .req_addr(req_addr), .wake_en(wake_en),
        .wr_data(wr_data), .wr_pop(wr_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- data sources / sinks ----------------
    logic [7:0] wr_mem [64];
    logic [7:0] rd_cap [64];
    int         wr_idx = 0;
    int         rd_n = 0;
    assign wr_data = wr_mem[wr_idx[5:0]];

    always @(posedge clk) begin
        if (wr_pop) wr_idx <= wr_idx + 1;
        if (rd_valid) begin
            if (rd_n < 64) rd_cap[rd_n] <= rd_data;
            rd_n <= rd_n + 1;
        end
    end

    // ---------------- behavioural SPI target ----------------
    int         cfg_stall = 0;
    logic [7:0] t_in = '0, t_out = '0, t_next = '0;
    int         t_bit = 0, t_byte = 0, t_zeros = 0, t_di = 0, t_polls = 0;
    bit         t_last_ready = 0, t_in_data = 0, t_load = 0, t_mosi_bad = 0;
    logic [7:0] t_hdr [4];
    logic [7:0] t_wcap [64];
    logic [7:0] t_rmem [64];
    logic       t_miso = 1'b0;
    assign miso = t_miso;

    always @(negedge cs_n) begin
        t_bit = 0; t_byte = 0; t_zeros = cfg_stall; t_in_data = 0;
        t_last_ready = 0; t_out = 8'h00; t_load = 0; t_miso = 1'b0;
    end

    always @(posedge sck) if (!cs_n) begin
        t_in = {t_in[6:0], mosi};
        t_bit++;
        if (t_bit == 8) begin
            t_bit = 0;
            t_load = 1;
            if (t_byte < 4) t_hdr[t_byte] = t_in;
            else if (!t_in_data) begin
                t_polls++;
                if (t_in != 8'h00) t_mosi_bad = 1;
            end else begin
                if (t_hdr[0][7]) begin
                    if (t_in != 8'h00) t_mosi_bad = 1;
                end else if (t_di < 64) t_wcap[t_di] = t_in;
                t_di++;
            end
            if (t_byte < 2) t_next = 8'h00;
            else if (t_byte >= 3 && !t_in_data && t_last_ready) begin
                t_in_data = 1;
                t_next = t_rmem[0];
            end else if (t_in_data) t_next = (t_di < 64) ? t_rmem[t_di] : 8'h00;
            else if (t_zeros == 0) begin
                t_next = 8'h01;
                t_last_ready = 1;
            end else begin
                t_next = 8'hFE;
                t_zeros--;
            end
            t_byte++;
        end
    end

    always @(negedge sck) if (!cs_n) begin
        if (t_load) begin
            t_out = t_next;
            t_load = 0;
        end else t_out = {t_out[6:0], 1'b0};
        t_miso = t_out[7];
    end

    // ---------------- chip select / clock monitor ----------------
    int falls = 0, low1 = 0, high1 = 0, gap1 = 0;
    bit prev_cs = 1'b1, sck_bad = 0;
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            falls++;
            if (falls == 2) gap1 = high1;
        end
        if (!cs_n && falls == 1) low1++;
        if (cs_n && falls == 1 && low1 > 0) high1++;
        if (cs_n && sck) sck_bad = 1;
        prev_cs = cs_n;
    end

    // ---------------- transaction driver ----------------
    bit got_err = 0, busy_drop = 0;

    task automatic do_xact(input bit rd, input int len, input logic [23:0] addr,
                           input bit wake, input int stall, input bit poke);
        int n;
        @(negedge clk);
        cfg_stall = stall; wr_idx = 0; rd_n = 0; falls = 0; low1 = 0; high1 = 0;
        gap1 = 0; t_polls = 0; t_di = 0; t_mosi_bad = 0; got_err = 0; busy_drop = 0;
        req_read = rd; req_len_m1 = 6'(len - 1); req_addr = addr; wake_en = wake;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            if (!busy) busy_drop = 1;
            if (poke && n == 10) begin
                req_read = 1'b0; req_addr = 24'h123456; req_valid = 1'b1;
            end else req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (n >= 20000) check(0, "watchdog: done never seen", 0, 1);
        got_err = err;
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check(cs_n === 1'b1, "R12 cs_n after reset", cs_n, 1);
        check(sck === 1'b0, "R12 sck after reset", sck, 0);
        check(busy === 1'b0 && done === 1'b0, "R12 busy/done after reset", {busy, done}, 0);
    endtask

    task automatic t_wake_first;
        do_xact(1'b0, 1, 24'h000F00, 1'b1, 0, 1'b0);
        check(falls == 2, "R7 wake pulse on first access", falls, 2);
        check(low1 == PULSE_US * CLK_MHZ, "R7 wake pulse width", low1, PULSE_US * CLK_MHZ);
        check(gap1 >= SETTLE_US * CLK_MHZ, "R7 settle before header", gap1, SETTLE_US * CLK_MHZ);
        do_xact(1'b0, 1, 24'h000F00, 1'b1, 0, 1'b0);
        check(falls == 1, "R8 no wake inside gap window", falls, 1);
        repeat (2 * GAP_US * CLK_MHZ) @(negedge clk);
        do_xact(1'b1, 1, 24'h000F04, 1'b1, 0, 1'b0);
        check(falls == 2, "R7 wake after long idle", falls, 2);
        repeat (2 * GAP_US * CLK_MHZ) @(negedge clk);
        do_xact(1'b1, 1, 24'h000F04, 1'b0, 0, 1'b0);
        check(falls == 1, "R8 no wake when mode disabled", falls, 1);
    endtask

    task automatic t_write_basic;
        do_xact(1'b0, 4, 24'hD40018, 1'b0, 0, 1'b0);
        check(t_hdr[0] == 8'h43, "R1 write header byte0", t_hdr[0], 8'h43);
        check(t_hdr[1] == 8'hD4 && t_hdr[2] == 8'h00 && t_hdr[3] == 8'h18,
              "R2 address bytes MSB first", {t_hdr[1], t_hdr[2], t_hdr[3]}, 24'hD40018);
        check(t_di == 4, "R3 write byte count", t_di, 4);
        for (int i = 0; i < 4; i++)
            check(t_wcap[i] == wr_mem[i], "R11 write data order", t_wcap[i], wr_mem[i]);
        check(wr_idx == 4, "R11 one pop per write byte", wr_idx, 4);
        check(falls == 1 && cs_n, "R4 single cs frame then release", falls, 1);
        check(t_polls == 0, "R5 ready in header skips polling", t_polls, 0);
        check(!got_err, "R6 no error without stall", got_err, 0);
    endtask

    task automatic t_read_stall;
        do_xact(1'b1, 3, 24'hD40024, 1'b0, 3, 1'b0);
        check(t_hdr[0] == 8'hC2, "R1 read header byte0", t_hdr[0], 8'hC2);
        check(t_polls == 3, "R5 poll bytes until bit0 set", t_polls, 3);
        check(rd_n == 3, "R3 read byte count", rd_n, 3);
        for (int i = 0; i < 3; i++)
            check(rd_cap[i] == t_rmem[i], "R11 read data order", rd_cap[i], t_rmem[i]);
        check(!t_mosi_bad, "R9 mosi zero on poll/read bytes", t_mosi_bad, 0);
        check(falls == 1, "R4 cs held across wait phase", falls, 1);
        check(!busy_drop, "R10 busy held until done", busy_drop, 0);
    endtask

    task automatic t_lengths;
        do_xact(1'b1, 1, 24'h00ABCD, 1'b0, 0, 1'b0);
        check(t_hdr[0] == 8'hC0, "R1 length 1 code", t_hdr[0], 8'hC0);
        check(rd_n == 1, "R3 minimum length", rd_n, 1);
        do_xact(1'b0, 64, 24'hFEDCBA, 1'b0, 1, 1'b0);
        check(t_hdr[0] == 8'h7F, "R1 length 64 code", t_hdr[0], 8'h7F);
        check(t_di == 64 && t_wcap[63] == wr_mem[63], "R3 maximum length", t_di, 64);
        check(t_hdr[1] == 8'hFE && t_hdr[3] == 8'hBA, "R2 address high/low", {t_hdr[1], t_hdr[3]}, 16'hFEBA);
    endtask

    task automatic t_timeout;
        do_xact(1'b1, 2, 24'h000018, 1'b0, 100000, 1'b0);
        check(got_err, "R6 error on wait limit", got_err, 1);
        check(t_di == 0 && rd_n == 0, "R6 no data after abort", t_di, 0);
        check(cs_n === 1'b1, "R6 cs released after abort", cs_n, 1);
        do_xact(1'b1, 1, 24'h000018, 1'b0, 0, 1'b0);
        check(!got_err && rd_n == 1, "R6 error clears on next access", got_err, 0);
    endtask

    task automatic t_busy_ignore;
        do_xact(1'b1, 8, 24'h00F904, 1'b0, 0, 1'b1);
        check(falls == 1 && t_hdr[0] == 8'hC7, "R10 request while busy ignored", t_hdr[0], 8'hC7);
        repeat (40) @(negedge clk);
        check(busy == 1'b0 && cs_n == 1'b1, "R10 no queued access afterwards", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            wr_mem[i] = 8'(8'h30 + i * 7);
            t_rmem[i] = 8'(8'hA0 ^ (i * 3));
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_wake_first();
        t_write_basic();
        t_read_stall();
        t_lengths();
        t_timeout();
        t_busy_ignore();
        check(!sck_bad, "R9 sck low while deselected", sck_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule